// File: doc/BRIEF.md
# Reuse-Filtered Cache Admission Buffer

This block is a small, fully associative holding buffer placed beside a first-level cache. Lines that miss in both the cache and the buffer do not go straight into the cache. They are fetched from the next level and parked in the buffer, where a small counter per word records how often each word is referenced. A line earns a place in the cache only when an admission predicate over those counters holds. Lines that are referenced only once or twice age out of the buffer and never pollute the cache.

Each cycle the block can accept one access: an address, a write flag and the main cache's hit flag, which is looked up in parallel. The block reports a buffer hit, a promote request with the line tag and its modified status, a fill request to the next level, and the fate of the entry displaced by a fill. A displaced entry is either written back or dropped. Line data storage, the cache itself and the next level are outside the block. Geometry, word size, threshold and predicate are parameters. The block-count predicate sums the references over the whole line. The word-count predicate looks for any one word that has reached the threshold.

Top module: `reuse_admit_buf`

## Requirements
- R1: After reset every entry is invalid and all outputs are low while no access is presented. Misses fill empty entries before any valid entry is displaced, so no write-back or drop is reported until every entry holds a line.
- R2: An access with `l1_hit` high causes no buffer hit, promote, fill, write-back or drop, and leaves the reference counts, dirty bits and entries unchanged.
- R3: An access that misses in both structures raises `fill_req` in the same cycle, with `fill_tag` equal to address bits above the line offset. The line is installed at the most recently used position, with a count of one on the referenced word.
- R4: A buffer hit whose updated counts do not satisfy the predicate raises `filt_hit` without `promote_valid` and moves the entry to the most recently used position.
- R5: In word-count mode (MODE = CNT_WORD, value 1) a hit promotes the line when one single word has reached THRESH references. References spread over different words do not promote.
- R6: In block-count mode (MODE = CNT_BLOCK, value 0) a hit promotes the line when the sum of the references over all its words reaches THRESH, regardless of which words they hit.
- R7: A promoted line is removed from the buffer. A later access to it misses, and the freed slot is filled before any valid entry is displaced.
- R8: When a fill finds every entry valid, the least recently used entry is displaced and `evict_tag` carries its tag. `wb_valid` is raised if that entry was modified, and `drop_valid` is raised otherwise.
- R9: A line is marked modified by a write miss that installs it or by a write hit while it is buffered. `promote_dirty` reports that state, including a write made by the promoting access itself.
- R10: The word index is the address field between log2(WORD_BYTES) and log2(LINE_BYTES). With 4-byte words, offsets 0x0 and 0x2 fall in the same word, while 0x0 and 0x4 fall in different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_write | input | 1 | Access is a store |
| l1_hit | input | 1 | Main cache hit for this access |
| filt_hit | output | 1 | Access hit a buffered line |
| promote_valid | output | 1 | Line leaves the buffer and enters the cache |
| promote_tag | output | ADDR_W-log2(LINE_BYTES) | Tag of the promoted line |
| promote_dirty | output | 1 | Promoted line is modified |
| fill_req | output | 1 | Request line from next level |
| fill_tag | output | ADDR_W-log2(LINE_BYTES) | Tag of the requested line |
| wb_valid | output | 1 | Displaced modified line must be written back |
| drop_valid | output | 1 | Displaced clean line is discarded |
| evict_tag | output | ADDR_W-log2(LINE_BYTES) | Tag of the displaced line |

## Verification
Two configurations are driven side by side: a word-count buffer with 4-byte words and a threshold of two, and a block-count buffer with 8-byte words and a threshold of three. Repeated references to one word, references spread over distinct words of one line, and references to byte offsets inside the same word show whether the predicate counts per word or per line and where the word index is taken. A stream of distinct lines past the capacity, with a buffered line touched in between, shows that the victim follows recency and not insertion order. Accesses flagged as main-cache hits and interleaved with buffer hits show that they leave the counts untouched.

// File: rtl/reuse_pkg.sv
package reuse_pkg;
   typedef enum logic {
      CNT_BLOCK = 1'b0,
      CNT_WORD  = 1'b1
   } admit_mode_e;
endpackage

// File: rtl/rab_lookup.sv
module rab_lookup #(
   parameter int ENTRIES = 64,
   parameter int TAG_W   = 26,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ENTRIES-1:0]              ent_valid,
   input  logic [ENTRIES-1:0][TAG_W-1:0]   ent_tag,
   input  logic [TAG_W-1:0]                key,
   output logic                            hit,
   output logic [IDX_W-1:0]                hit_idx
);
   logic [ENTRIES-1:0] match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = ent_valid[g] && (ent_tag[g] == key);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) hit_idx = hit_idx | IDX_W'(i);
      end
   end

   assign hit = |match;

   // A line is never held twice, so at most one entry matches (R3)
   assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
endmodule

// File: rtl/rab_lru.sv
module rab_lru #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ENTRIES-1:0]   ent_valid,
   input  logic                 touch_en,
   input  logic [IDX_W-1:0]     touch_idx,
   input  logic                 demote_en,
   input  logic [IDX_W-1:0]     demote_idx,
   output logic [IDX_W-1:0]     victim_idx
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   logic [ENTRIES-1:0][IDX_W-1:0] age_q, age_d;
   logic [ENTRIES-1:0]            oldest_flag;
   logic [IDX_W-1:0]              ref_age;
   logic                          found_free;

   always_comb begin
      found_free = 1'b0;
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!ent_valid[i] && !found_free) begin
            victim_idx = IDX_W'(i);
            found_free = 1'b1;
         end
      end
      if (!found_free) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      age_d   = age_q;
      ref_age = touch_en ? age_q[touch_idx] : age_q[demote_idx];
      if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch_idx)  age_d[i] = '0;
            else if (age_q[i] < ref_age) age_d[i] = age_q[i] + 1'b1;
         end
      end else if (demote_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == demote_idx) age_d[i] = OLDEST;
            else if (age_q[i] > ref_age) age_d[i] = age_q[i] - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else begin
         age_q <= age_d;
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_old
      assign oldest_flag[g] = (age_q[g] == OLDEST);
   end

   // The recency order stays a permutation: exactly one oldest entry (R4)
   assert_single_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_flag) == 1);

   // Touch and demote never collide in one cycle (R7)
   assert_touch_demote_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(touch_en && demote_en));
endmodule

// File: rtl/rab_admit.sv
module rab_admit
   import reuse_pkg::*;
#(
   parameter admit_mode_e MODE = CNT_BLOCK,
   parameter int WORDS  = 8,
   parameter int THRESH = 3,
   localparam int CNT_W = $clog2(THRESH + 1),
   localparam int SUM_W = $clog2(WORDS * THRESH + 1)
) (
   input  logic [WORDS-1:0][CNT_W-1:0] counts,
   output logic                        qualify
);
   if (MODE == CNT_WORD) begin : g_word
      always_comb begin
         qualify = 1'b0;
         for (int i = 0; i < WORDS; i++) begin
            if (counts[i] >= CNT_W'(THRESH)) qualify = 1'b1;
         end
      end
   end else begin : g_block
      logic [SUM_W-1:0] total;
      always_comb begin
         total = '0;
         for (int i = 0; i < WORDS; i++) total = total + SUM_W'(counts[i]);
         qualify = (total >= SUM_W'(THRESH));
      end
   end
endmodule

// File: rtl/reuse_admit_buf.sv
module reuse_admit_buf
   import reuse_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int ENTRIES    = 64,
   parameter int LINE_BYTES = 64,
   parameter int WORD_BYTES = 8,
   parameter int THRESH     = 3,
   parameter admit_mode_e MODE = CNT_BLOCK
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 acc_valid,
   input  logic [ADDR_W-1:0]                    acc_addr,
   input  logic                                 acc_write,
   input  logic                                 l1_hit,
   output logic                                 filt_hit,
   output logic                                 promote_valid,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] promote_tag,
   output logic                                 promote_dirty,
   output logic                                 fill_req,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] fill_tag,
   output logic                                 wb_valid,
   output logic                                 drop_valid,
   output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] evict_tag
);
   localparam int LINE_OFF = $clog2(LINE_BYTES);
   localparam int WORD_OFF = $clog2(WORD_BYTES);
   localparam int WORDS    = LINE_BYTES / WORD_BYTES;
   localparam int WIDX_W   = $clog2(WORDS);
   localparam int TAG_W    = ADDR_W - LINE_OFF;
   localparam int IDX_W    = $clog2(ENTRIES);
   localparam int CNT_W    = $clog2(THRESH + 1);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two of at least 2");
   end
   if (WORDS < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two holding at least 2 words");
   end
   if (THRESH < 1) begin : g_bad_thresh
      $error("THRESH must be at least 1");
   end
   if (LINE_OFF >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset");
   end

   logic [ENTRIES-1:0]                         valid_q;
   logic [ENTRIES-1:0]                         dirty_q;
   logic [ENTRIES-1:0][TAG_W-1:0]              tag_q;
   logic [ENTRIES-1:0][WORDS-1:0][CNT_W-1:0]   cnt_q;

   logic [TAG_W-1:0]              tag_in;
   logic [WIDX_W-1:0]             word_in;
   logic                          addr_lsb_unused;
   logic                          live;
   logic                          hit_raw;
   logic [IDX_W-1:0]              hit_idx;
   logic [IDX_W-1:0]              victim_idx;
   logic [WORDS-1:0][CNT_W-1:0]   upd_cnt;
   logic [WORDS-1:0][CNT_W-1:0]   new_cnt;
   logic                          qualify;
   logic                          victim_used;
   logic                          stay;

   assign tag_in          = acc_addr[ADDR_W-1:LINE_OFF];
   assign word_in         = acc_addr[LINE_OFF-1:WORD_OFF];
   assign addr_lsb_unused = ^acc_addr[WORD_OFF-1:0];
   assign live            = acc_valid && !l1_hit;

   rab_lookup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lookup (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_valid (valid_q),
      .ent_tag   (tag_q),
      .key       (tag_in),
      .hit       (hit_raw),
      .hit_idx   (hit_idx)
   );

   always_comb begin
      upd_cnt = cnt_q[hit_idx];
      if (upd_cnt[word_in] < CNT_W'(THRESH)) upd_cnt[word_in] = upd_cnt[word_in] + 1'b1;
      new_cnt = '0;
      new_cnt[word_in] = CNT_W'(1);
   end

   rab_admit #(.MODE(MODE), .WORDS(WORDS), .THRESH(THRESH)) u_admit (
      .counts  (upd_cnt),
      .qualify (qualify)
   );

   assign filt_hit      = live && hit_raw;
   assign promote_valid = filt_hit && qualify;
   assign promote_tag   = tag_in;
   assign promote_dirty = promote_valid && (dirty_q[hit_idx] || acc_write);
   assign stay          = filt_hit && !qualify;

   assign fill_req    = live && !hit_raw;
   assign fill_tag    = tag_in;
   assign victim_used = valid_q[victim_idx];
   assign wb_valid    = fill_req && victim_used && dirty_q[victim_idx];
   assign drop_valid  = fill_req && victim_used && !dirty_q[victim_idx];
   assign evict_tag   = tag_q[victim_idx];

   rab_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .ent_valid  (valid_q),
      .touch_en   (stay || fill_req),
      .touch_idx  (fill_req ? victim_idx : hit_idx),
      .demote_en  (promote_valid),
      .demote_idx (hit_idx),
      .victim_idx (victim_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         tag_q   <= '0;
         cnt_q   <= '0;
      end else if (promote_valid) begin
         valid_q[hit_idx] <= 1'b0;
         dirty_q[hit_idx] <= 1'b0;
      end else if (stay) begin
         cnt_q[hit_idx]   <= upd_cnt;
         dirty_q[hit_idx] <= dirty_q[hit_idx] || acc_write;
      end else if (fill_req) begin
         valid_q[victim_idx] <= 1'b1;
         dirty_q[victim_idx] <= acc_write;
         tag_q[victim_idx]   <= tag_in;
         cnt_q[victim_idx]   <= new_cnt;
      end
   end

   // Main-cache hits leave the buffer state alone (R2)
   assert_l1_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && l1_hit) |=> ($stable(valid_q) && $stable(dirty_q) && $stable(cnt_q)));

   // Displacement only happens when no empty slot remains (R1, R8)
   assert_evict_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid || drop_valid) |-> (&valid_q));

   // A promotion always frees a slot (R7)
   assert_promote_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
      promote_valid |=> !(&valid_q));

   // A fill leaves the requested line resident (R3)
   assert_fill_installs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |=> valid_q[$past(victim_idx)]);
endmodule

// File: tb/test_reuse_admit_buf.sv
module test_reuse_admit_buf;
   import reuse_pkg::*;

   localparam int TW = 26;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          a_v = 0, a_w = 0, a_l1 = 0, b_v = 0, b_w = 0, b_l1 = 0;
   logic [31:0]   a_addr = '0, b_addr = '0;
   logic          a_hit, a_pv, a_pd, a_fr, a_wb, a_dr;
   logic [TW-1:0] a_pt, a_ft, a_et;
   logic          b_hit, b_pv, b_pd, b_fr, b_wb, b_dr;
   logic [TW-1:0] b_pt, b_ft, b_et;

   reuse_admit_buf #(.ENTRIES(4), .LINE_BYTES(64), .WORD_BYTES(4), .THRESH(2), .MODE(CNT_WORD))
   i_reuse_admit_buf (
      .clk(clk), .rst_n(rst_n), .acc_valid(a_v), .acc_addr(a_addr), .acc_write(a_w), .l1_hit(a_l1),
      .filt_hit(a_hit), .promote_valid(a_pv), .promote_tag(a_pt), .promote_dirty(a_pd),
      .fill_req(a_fr), .fill_tag(a_ft), .wb_valid(a_wb), .drop_valid(a_dr), .evict_tag(a_et));

   reuse_admit_buf #(.ENTRIES(4), .LINE_BYTES(64), .WORD_BYTES(8), .THRESH(3), .MODE(CNT_BLOCK))
   i_reuse_admit_buf_blk (
      .clk(clk), .rst_n(rst_n), .acc_valid(b_v), .acc_addr(b_addr), .acc_write(b_w), .l1_hit(b_l1),
      .filt_hit(b_hit), .promote_valid(b_pv), .promote_tag(b_pt), .promote_dirty(b_pd),
      .fill_req(b_fr), .fill_tag(b_ft), .wb_valid(b_wb), .drop_valid(b_dr), .evict_tag(b_et));

   int n_checks = 0;
   int n_fail = 0;
   logic o_hit, o_pv, o_pd, o_fr, o_wb, o_dr;
   logic [TW-1:0] o_pt, o_ft, o_et;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic grab(input bit blk);
      o_hit = blk ? b_hit : a_hit;  o_pv = blk ? b_pv : a_pv;  o_pd = blk ? b_pd : a_pd;
      o_fr  = blk ? b_fr  : a_fr;   o_wb = blk ? b_wb : a_wb;  o_dr = blk ? b_dr : a_dr;
      o_pt  = blk ? b_pt  : a_pt;   o_ft = blk ? b_ft : a_ft;  o_et = blk ? b_et : a_et;
   endtask

   // One access: drive at the falling edge, sample 1 ns later, commit at the rising edge
   task automatic acc(input bit blk, input logic [31:0] addr, input bit wr, input bit l1);
      @(negedge clk);
      if (blk) begin b_v = 1; b_addr = addr; b_w = wr; b_l1 = l1; end
      else     begin a_v = 1; a_addr = addr; a_w = wr; a_l1 = l1; end
      #1 grab(blk);
      @(posedge clk);
      #1;
      a_v = 0; a_w = 0; a_l1 = 0; b_v = 0; b_w = 0; b_l1 = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk); #1 grab(0);
      chk("R1", "idle outputs", {o_hit, o_pv, o_fr, o_wb, o_dr}, 0);
      grab(1);
      chk("R1", "idle outputs blk", {o_hit, o_pv, o_fr, o_wb, o_dr}, 0);
      acc(0, 32'h0000, 0, 0);
      chk("R3", "first miss fill", o_fr, 1);
      chk("R3", "fill tag", o_ft, 0);
      chk("R1", "no displacement", {o_wb, o_dr}, 0);
      chk("R3", "no buffer hit on miss", o_hit, 0);
   endtask

   task automatic t_lru();
      do_reset();
      acc(0, 32'h000, 0, 0);
      acc(0, 32'h040, 1, 0);
      chk("R3", "fill tag line1", o_ft, 1);
      acc(0, 32'h080, 0, 0);
      acc(0, 32'h0C0, 0, 0);
      chk("R1", "fourth fill uses empty slot", {o_fr, o_wb, o_dr}, 3'b100);
      acc(0, 32'h004, 0, 0);
      chk("R4", "hit without promote", {o_hit, o_pv}, 2'b10);
      acc(0, 32'h100, 0, 0);
      chk("R8", "dirty victim written back", {o_fr, o_wb, o_dr}, 3'b110);
      chk("R8", "victim is line1 not line0 (R4 recency)", o_et, 1);
      acc(0, 32'h140, 0, 0);
      chk("R8", "clean victim dropped", {o_wb, o_dr}, 2'b01);
      chk("R8", "drop tag", o_et, 2);
      acc(0, 32'h004, 0, 0);
      chk("R5", "second ref to word promotes", o_pv, 1);
      chk("R5", "promote tag", o_pt, 0);
      chk("R9", "clean promote", o_pd, 0);
      acc(0, 32'h180, 0, 0);
      chk("R7", "freed slot filled first", {o_fr, o_wb, o_dr}, 3'b100);
      acc(0, 32'h000, 0, 0);
      chk("R7", "promoted line misses again", {o_hit, o_fr}, 2'b01);
      chk("R8", "oldest line dropped", {o_dr, 26'(o_et)}, {1'b1, 26'd3});
   endtask

   task automatic t_word();
      do_reset();
      acc(0, 32'h200, 0, 0);
      acc(0, 32'h204, 0, 0);
      chk("R10", "offset 4 is another word", {o_hit, o_pv}, 2'b10);
      acc(0, 32'h208, 0, 0);
      chk("R5", "spread refs do not promote", {o_hit, o_pv}, 2'b10);
      acc(0, 32'h202, 0, 0);
      chk("R10", "offset 2 shares word 0", o_pv, 1);
      chk("R5", "promote tag", o_pt, 8);
      acc(0, 32'h000, 0, 1);
      chk("R2", "l1 hit on absent line no fill", {o_hit, o_fr, o_wb, o_dr}, 0);
   endtask

   task automatic t_dirty();
      do_reset();
      acc(0, 32'h300, 0, 0);
      acc(0, 32'h300, 1, 0);
      chk("R9", "write on promoting hit", {o_pv, o_pd}, 2'b11);
      acc(0, 32'h340, 1, 0);
      acc(0, 32'h340, 0, 0);
      chk("R9", "write miss marks dirty", {o_pv, o_pd}, 2'b11);
      acc(0, 32'h380, 0, 0);
      acc(0, 32'h384, 1, 0);
      chk("R9", "write hit stays", {o_hit, o_pv}, 2'b10);
      acc(0, 32'h384, 0, 0);
      chk("R9", "earlier write hit kept", {o_pv, o_pd}, 2'b11);
   endtask

   task automatic t_block();
      do_reset();
      acc(1, 32'h000, 0, 0);
      chk("R3", "blk miss fill", o_fr, 1);
      acc(1, 32'h000, 1, 1);
      chk("R2", "l1 hit silent", {o_hit, o_pv, o_fr, o_wb, o_dr}, 0);
      acc(1, 32'h000, 0, 0);
      chk("R2", "l1 hit not counted", {o_hit, o_pv}, 2'b10);
      acc(1, 32'h038, 0, 0);
      chk("R6", "third ref across words promotes", o_pv, 1);
      chk("R2", "l1 hit left line clean", o_pd, 0);
      acc(1, 32'h400, 0, 0);
      acc(1, 32'h408, 0, 0);
      chk("R6", "two refs do not promote", {o_hit, o_pv}, 2'b10);
      acc(1, 32'h410, 0, 0);
      chk("R6", "sum of three promotes", {o_pv, 26'(o_pt)}, {1'b1, 26'h10});
   endtask

   bit done = 0;

   initial begin
      t_reset();
      t_lru();
      t_word();
      t_dirty();
      t_block();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule